// File: doc/BRIEF.md
# Three-Operation 16-bit Operate Unit

This block is the value-computing part of the register-to-register operate class in a small 16-bit load/store processor. It knows three primitives: two's-complement addition, bitwise AND and bitwise NOT. For ADD and AND, a mode bit picks the second operand. It is either a second register value or a 5-bit immediate that is sign-extended to 16 bits. NOT reads only the first operand. Addition wraps modulo 2^16, and the block has no carry or overflow output.

A small sequencer sits around the primitive datapath. It builds subtract, OR, copy and clear out of fixed chains of the three primitives. Each step of a chain writes one of three internal working registers: A, B or D. Subtract runs NOT B, then B+1, then A+B. OR runs NOT A, NOT B, AND, then NOT (De Morgan). Copy is an ADD of immediate 0. Clear is an AND with immediate 0.

A request is accepted only in the idle state. The unit then walks through its step states and raises `done` for one cycle with the final value on `result`. Register-file access, condition codes and instruction fetch belong to neighbouring blocks.

The state machine has six states:
- `ST_IDLE` waits for a request.
- `ST_STEP0` to `ST_STEP3` each execute one primitive.
- `ST_DONE` presents the completion strobe.

Its transitions are as follows:
- IDLE goes to STEP0 on an accepted request.
- A step state goes to DONE when its step is the last of the command. Otherwise it goes to the next step state.
- STEP3 always goes to DONE.
- DONE always returns to IDLE.

Top module: `opu_top`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `result` is 0.
- R2: Command 0 (single primitive) with op 0 (ADD) and mode 0 yields `src_a + src_b` modulo 2^16.
- R3: With mode 1, ADD and AND use `imm5` sign-extended from bit 4 (range −16 to +15) as the second operand, and `src_b` is not used.
- R4: Command 0 with op 1 (AND) and mode 0 yields `src_a & src_b`.
- R5: Command 0 with op 2 (NOT) yields `~src_a`, whatever `mode`, `src_b` and `imm5` hold.
- R6: Command 1 (subtract) takes three steps and yields `src_a - src_b` modulo 2^16.
- R7: Command 2 (OR) takes four steps and yields `src_a | src_b`.
- R8: Command 3 (copy) yields `src_a`, and command 4 (clear) yields 0. Each takes one step.
- R9: `done` is a one-cycle pulse and rises in the cycle after the last step. A request accepted at clock edge k with S steps gives `done` = 1 during the cycle after edge k+S.
- R10: `busy` is 1 from the accepting edge through the `done` cycle and is 0 in the cycle after `done`. Requests presented while `busy` is 1 are ignored and do not change the running command's result.
- R11: A request with command 5 to 7, or command 0 with op 3, is ignored: `busy` stays 0, no `done` follows, and `result` keeps its value.
- R12: `result` changes only at the edge that starts a `done` cycle and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_cmd | input | 3 | Command: 0 primitive, 1 subtract, 2 OR, 3 copy, 4 clear |
| req_op | input | 2 | Primitive for command 0: 0 ADD, 1 AND, 2 NOT |
| req_mode | input | 1 | 0 second register, 1 sign-extended immediate |
| src_a | input | 16 | First register operand |
| src_b | input | 16 | Second register operand |
| imm5 | input | 5 | Immediate field, two's complement |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion strobe |
| result | output | 16 | Final value of the last completed command |

## Verification
The bound checker keeps its own copy of every accepted request and tests a set of properties on every clock cycle. It compares the completed value against an independent model for each command. It also checks that `done` is a one-cycle pulse, that `done` comes after the step count fixed for the command, that `busy` rises after an acceptance and drops after `done`, that reserved requests leave the unit idle, and that `result` is stable outside `done` cycles.

Some behaviours only the bench scenarios can show:
- The reset values.
- That a request issued mid-sequence neither starts a second command nor disturbs the first result.
- That NOT ignores its unused inputs.
- The extremes of the immediate range and of wrap-around.

// File: rtl/opu_pkg.sv
package opu_pkg;

    // primitive operations; encoding is the req_op field
    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_AND = 2'd1,
        OP_NOT = 2'd2,
        OP_RSV = 2'd3
    } prim_e;

    // commands; encoding is the req_cmd field
    typedef enum logic [2:0] {
        CMD_PRIM  = 3'd0,
        CMD_SUB   = 3'd1,
        CMD_OR    = 3'd2,
        CMD_COPY  = 3'd3,
        CMD_CLEAR = 3'd4,
        CMD_RSV5  = 3'd5,
        CMD_RSV6  = 3'd6,
        CMD_RSV7  = 3'd7
    } cmd_e;

    // operand / destination selectors for one micro step
    typedef enum logic [2:0] {
        SEL_A    = 3'd0,
        SEL_B    = 3'd1,
        SEL_D    = 3'd2,
        SEL_IMM  = 3'd3,
        SEL_ONE  = 3'd4,
        SEL_ZERO = 3'd5
    } sel_e;

    typedef struct packed {
        prim_e op;
        sel_e  src1;
        sel_e  src2;
        sel_e  dst;
        logic  last;
    } uop_t;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_STEP0 = 3'd1,
        ST_STEP1 = 3'd2,
        ST_STEP2 = 3'd3,
        ST_STEP3 = 3'd4,
        ST_DONE  = 3'd5
    } st_e;

    localparam int MAX_STEPS = 4;

endpackage

// File: rtl/opu_alu.sv
module opu_alu
    import opu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  prim_e              op,
    input  logic [DATA_W-1:0]  x,
    input  logic [DATA_W-1:0]  y,
    output logic [DATA_W-1:0]  z
);

    // addition wraps: carry out is dropped by the result width
    always_comb begin
        case (op)
            OP_ADD:  z = x + y;
            OP_AND:  z = x & y;
            OP_NOT:  z = ~x;
            default: z = ~x;
        endcase
    end

endmodule

// File: rtl/opu_opsel.sv
module opu_opsel
    import opu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int IMM_W  = 5
) (
    input  sel_e               sel,
    input  logic [DATA_W-1:0]  reg_a,
    input  logic [DATA_W-1:0]  reg_b,
    input  logic [DATA_W-1:0]  reg_d,
    input  logic [IMM_W-1:0]   imm,
    output logic [DATA_W-1:0]  val
);

    localparam int EXT_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_ext;

    // replicate the immediate sign bit into the upper bits
    assign imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};

    always_comb begin
        case (sel)
            SEL_A:    val = reg_a;
            SEL_B:    val = reg_b;
            SEL_D:    val = reg_d;
            SEL_IMM:  val = imm_ext;
            SEL_ONE:  val = DATA_W'(1);
            SEL_ZERO: val = '0;
            default:  val = '0;
        endcase
    end

endmodule

// File: rtl/opu_seq.sv
module opu_seq
    import opu_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start,
    input  cmd_e  cmd,
    input  prim_e prim,
    input  logic  mode,
    output st_e   state,
    output uop_t  uop,
    output logic  step_en,
    output logic  busy,
    output logic  done
);

    st_e        nxt;
    logic [1:0] step_idx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start) nxt = ST_STEP0;
            ST_STEP0: nxt = uop.last ? ST_DONE : ST_STEP1;
            ST_STEP1: nxt = uop.last ? ST_DONE : ST_STEP2;
            ST_STEP2: nxt = uop.last ? ST_DONE : ST_STEP3;
            ST_STEP3: nxt = ST_DONE;
            ST_DONE:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // step index from the step state
    always_comb begin
        unique case (state)
            ST_STEP1: step_idx = 2'd1;
            ST_STEP2: step_idx = 2'd2;
            ST_STEP3: step_idx = 2'd3;
            default:  step_idx = 2'd0;
        endcase
    end

    // outputs and micro-step table
    always_comb begin
        step_en = (state == ST_STEP0) || (state == ST_STEP1) ||
                  (state == ST_STEP2) || (state == ST_STEP3);
        busy    = (state != ST_IDLE);
        done    = (state == ST_DONE);
        uop     = '{op: OP_ADD, src1: SEL_A, src2: SEL_ZERO, dst: SEL_D, last: 1'b1};
        unique case (cmd)
            CMD_PRIM: begin
                uop.op   = prim;
                uop.src1 = SEL_A;
                uop.src2 = mode ? SEL_IMM : SEL_B;
                uop.dst  = SEL_D;
                uop.last = 1'b1;
            end
            CMD_SUB: begin
                unique case (step_idx)
                    2'd0: uop = '{op: OP_NOT, src1: SEL_B, src2: SEL_ZERO, dst: SEL_B, last: 1'b0};
                    2'd1: uop = '{op: OP_ADD, src1: SEL_B, src2: SEL_ONE,  dst: SEL_B, last: 1'b0};
                    default: uop = '{op: OP_ADD, src1: SEL_A, src2: SEL_B, dst: SEL_D, last: 1'b1};
                endcase
            end
            CMD_OR: begin
                unique case (step_idx)
                    2'd0: uop = '{op: OP_NOT, src1: SEL_A, src2: SEL_ZERO, dst: SEL_A, last: 1'b0};
                    2'd1: uop = '{op: OP_NOT, src1: SEL_B, src2: SEL_ZERO, dst: SEL_B, last: 1'b0};
                    2'd2: uop = '{op: OP_AND, src1: SEL_A, src2: SEL_B,    dst: SEL_D, last: 1'b0};
                    default: uop = '{op: OP_NOT, src1: SEL_D, src2: SEL_ZERO, dst: SEL_D, last: 1'b1};
                endcase
            end
            CMD_COPY:
                uop = '{op: OP_ADD, src1: SEL_A, src2: SEL_ZERO, dst: SEL_D, last: 1'b1};
            CMD_CLEAR:
                uop = '{op: OP_AND, src1: SEL_A, src2: SEL_ZERO, dst: SEL_D, last: 1'b1};
            default:
                uop = '{op: OP_ADD, src1: SEL_A, src2: SEL_ZERO, dst: SEL_D, last: 1'b1};
        endcase
    end

endmodule

// File: rtl/opu_top.sv
module opu_top
    import opu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int IMM_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_cmd,
    input  logic [1:0]        req_op,
    input  logic              req_mode,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [IMM_W-1:0]  imm5,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] result
);

    cmd_e              cmd_q;
    prim_e             prim_q;
    logic              mode_q;
    logic [IMM_W-1:0]  imm_q;
    logic [DATA_W-1:0] wa, wb, wd, res_q;
    logic [DATA_W-1:0] opnd1, opnd2, alu_z;
    logic              legal, accept, step_en;
    st_e               state;
    uop_t              uop;

    // reserved commands and the reserved primitive are refused
    assign legal  = (req_cmd <= 3'd4) &&
                    !((req_cmd == 3'd0) && (req_op == 2'd3));
    assign accept = req_valid && !busy && legal;

    opu_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (accept),
        .cmd     (cmd_q),
        .prim    (prim_q),
        .mode    (mode_q),
        .state   (state),
        .uop     (uop),
        .step_en (step_en),
        .busy    (busy),
        .done    (done)
    );

    opu_opsel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_sel1 (
        .sel   (uop.src1),
        .reg_a (wa),
        .reg_b (wb),
        .reg_d (wd),
        .imm   (imm_q),
        .val   (opnd1)
    );

    opu_opsel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_sel2 (
        .sel   (uop.src2),
        .reg_a (wa),
        .reg_b (wb),
        .reg_d (wd),
        .imm   (imm_q),
        .val   (opnd2)
    );

    opu_alu #(.DATA_W(DATA_W)) u_alu (
        .op (uop.op),
        .x  (opnd1),
        .y  (opnd2),
        .z  (alu_z)
    );

    // request capture and working-register write-back
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= CMD_PRIM;
            prim_q <= OP_ADD;
            mode_q <= 1'b0;
            imm_q  <= '0;
            wa     <= '0;
            wb     <= '0;
            wd     <= '0;
            res_q  <= '0;
        end else if (accept) begin
            cmd_q  <= cmd_e'(req_cmd);
            prim_q <= prim_e'(req_op);
            mode_q <= req_mode;
            imm_q  <= imm5;
            wa     <= src_a;
            wb     <= src_b;
            wd     <= '0;
        end else if (step_en) begin
            unique case (uop.dst)
                SEL_A:   wa <= alu_z;
                SEL_B:   wb <= alu_z;
                default: wd <= alu_z;
            endcase
            if (uop.last) res_q <= alu_z;
        end
    end

    assign result = res_q;

endmodule

// File: rtl/opu_chk.sv
module opu_chk #(
    parameter int DATA_W = 16,
    parameter int IMM_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [2:0]        req_cmd,
    input logic [1:0]        req_op,
    input logic              req_mode,
    input logic [DATA_W-1:0] src_a,
    input logic [DATA_W-1:0] src_b,
    input logic [IMM_W-1:0]  imm5,
    input logic              busy,
    input logic              done,
    input logic [DATA_W-1:0] result
);

    logic [2:0]        c_cmd;
    logic [1:0]        c_op;
    logic              c_mode;
    logic [DATA_W-1:0] c_a, c_b;
    logic [IMM_W-1:0]  c_imm;
    logic [3:0]        cnt;
    logic              ok_req, acc, bad_req;

    assign ok_req  = (req_cmd <= 3'd4) && !((req_cmd == 3'd0) && (req_op == 2'd3));
    assign acc     = req_valid && !busy && ok_req;
    assign bad_req = req_valid && !busy && !ok_req;

    function automatic logic [3:0] steps_of(input logic [2:0] c);
        case (c)
            3'd1:    return 4'd3;
            3'd2:    return 4'd4;
            default: return 4'd1;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] model(
        input logic [2:0] c, input logic [1:0] o, input logic m,
        input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b,
        input logic [IMM_W-1:0] i);
        logic [DATA_W-1:0] second;
        second = m ? DATA_W'($signed(i)) : b;
        case (c)
            3'd1: return a - b;
            3'd2: return a | b;
            3'd3: return a;
            3'd4: return '0;
            default:
                case (o)
                    2'd0:    return a + second;
                    2'd1:    return a & second;
                    default: return ~a;
                endcase
        endcase
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_cmd <= '0; c_op <= '0; c_mode <= 1'b0;
            c_a <= '0; c_b <= '0; c_imm <= '0; cnt <= '0;
        end else if (acc) begin
            c_cmd <= req_cmd; c_op <= req_op; c_mode <= req_mode;
            c_a <= src_a; c_b <= src_b; c_imm <= imm5; cnt <= 4'd1;
        end else if (busy) begin
            cnt <= cnt + 4'd1;
        end
    end

    logic [DATA_W-1:0] exp_v;
    assign exp_v = model(c_cmd, c_op, c_mode, c_a, c_b, c_imm);

    assert_add_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && c_cmd == 3'd0 && c_op == 2'd0 && !c_mode) |-> result == exp_v);
    assert_imm_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && c_cmd == 3'd0 && c_op != 2'd2 && c_mode) |-> result == exp_v);
    assert_and_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && c_cmd == 3'd0 && c_op == 2'd1 && !c_mode) |-> result == exp_v);
    assert_not_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && c_cmd == 3'd0 && c_op == 2'd2) |-> result == ~c_a);
    assert_sub_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && c_cmd == 3'd1) |-> result == exp_v);
    assert_or_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && c_cmd == 3'd2) |-> result == exp_v);
    assert_copy_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (c_cmd == 3'd3 || c_cmd == 3'd4)) |-> result == exp_v);
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cnt == steps_of(c_cmd) + 4'd1);
    assert_accept_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> busy);
    assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    assert_reject_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bad_req |=> !busy);
    assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));

endmodule

bind opu_top opu_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_cmd   (req_cmd),
    .req_op    (req_op),
    .req_mode  (req_mode),
    .src_a     (src_a),
    .src_b     (src_b),
    .imm5      (imm5),
    .busy      (busy),
    .done      (done),
    .result    (result)
);

// File: tb/opu_top_bench.sv
module opu_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_cmd = '0;
    logic [1:0]  req_op = '0;
    logic        req_mode = 1'b0;
    logic [15:0] src_a = '0;
    logic [15:0] src_b = '0;
    logic [4:0]  imm5 = '0;
    logic        busy, done;
    logic [15:0] result;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    opu_top u_opu_top (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_op(req_op), .req_mode(req_mode), .src_a(src_a), .src_b(src_b),
        .imm5(imm5), .busy(busy), .done(done), .result(result)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int steps_of(input logic [2:0] c);
        case (c)
            3'd1: return 3;
            3'd2: return 4;
            default: return 1;
        endcase
    endfunction

    function automatic logic [15:0] expect_val(input logic [2:0] c, input logic [1:0] o,
        input logic m, input logic [15:0] a, input logic [15:0] b, input logic [4:0] i);
        logic [15:0] s;
        s = m ? {{11{i[4]}}, i} : b;
        case (c)
            3'd1: return a - b;
            3'd2: return a | b;
            3'd3: return a;
            3'd4: return 16'h0;
            default: case (o)
                2'd0: return a + s;
                2'd1: return a & s;
                default: return ~a;
            endcase
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] c, input logic [1:0] o, input logic m);
        if (c == 3'd1) return "R6";
        if (c == 3'd2) return "R7";
        if (c >= 3'd3) return "R8";
        if (o == 2'd2) return "R5";
        if (m) return "R3";
        return (o == 2'd0) ? "R2" : "R4";
    endfunction

    // issue one request and check latency and value
    task automatic run_op(input logic [2:0] c, input logic [1:0] o, input logic m,
                          input logic [15:0] a, input logic [15:0] b, input logic [4:0] i);
        int n;
        @(negedge clk);
        req_valid = 1'b1; req_cmd = c; req_op = o; req_mode = m;
        src_a = a; src_b = b; imm5 = i;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!done && n < 10) begin
            @(negedge clk);
            n++;
        end
        check("R9 latency", 32'(n), 32'(steps_of(c)));
        check(tag_of(c, o, m), {16'h0, result}, {16'h0, expect_val(c, o, m, a, b, i)});
        @(negedge clk);
        check("R9 done pulse", {31'h0, done}, 32'h0);
        check("R10 release", {31'h0, busy}, 32'h0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        logic [15:0] held;
        void'($urandom(32'h0C0FFEE5));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy", {31'h0, busy}, 32'h0);
        check("R1 done", {31'h0, done}, 32'h0);
        check("R1 result", {16'h0, result}, 32'h0);

        // directed corners
        run_op(3'd0, 2'd0, 1'b0, 16'hFFFF, 16'h0002, 5'h00);      // R2 wrap
        run_op(3'd0, 2'd0, 1'b1, 16'h0005, 16'hAAAA, 5'h10);      // R3 -16
        run_op(3'd0, 2'd0, 1'b1, 16'h0005, 16'hAAAA, 5'h0F);      // R3 +15
        run_op(3'd0, 2'd1, 1'b1, 16'h1234, 16'h0000, 5'h1C);      // R3 AND -4
        run_op(3'd0, 2'd1, 1'b0, 16'hF0F0, 16'h3C3C, 5'h00);      // R4
        run_op(3'd0, 2'd2, 1'b1, 16'h00FF, 16'h1234, 5'h0A);      // R5
        run_op(3'd1, 2'd0, 1'b0, 16'h0003, 16'h0005, 5'h00);      // R6 negative
        run_op(3'd1, 2'd0, 1'b0, 16'h8000, 16'h0001, 5'h00);      // R6 wrap
        run_op(3'd2, 2'd0, 1'b0, 16'hA000, 16'h0005, 5'h00);      // R7
        run_op(3'd3, 2'd0, 1'b0, 16'hBEEF, 16'h1111, 5'h1F);      // R8 copy
        run_op(3'd4, 2'd0, 1'b0, 16'hBEEF, 16'h1111, 5'h1F);      // R8 clear

        // R10: a request while busy is ignored
        @(negedge clk);
        req_valid = 1'b1; req_cmd = 3'd1; req_op = 2'd0; req_mode = 1'b0;
        src_a = 16'h0100; src_b = 16'h0001; imm5 = '0;
        @(negedge clk);
        req_cmd = 3'd0; src_a = 16'h7777; src_b = 16'h1111;
        check("R10 busy", {31'h0, busy}, 32'h1);
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check("R10 done", {31'h0, done}, 32'h1);
        check("R10 result", {16'h0, result}, 32'h00FF);
        repeat (3) begin
            @(negedge clk);
            check("R10 no second done", {31'h0, done}, 32'h0);
        end

        // R11: reserved command and reserved primitive
        held = result;
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            req_valid = 1'b1; req_cmd = (k == 0) ? 3'd6 : 3'd0; req_op = 2'd3;
            src_a = 16'h4321;
            @(negedge clk);
            req_valid = 1'b0;
            check("R11 busy", {31'h0, busy}, 32'h0);
            repeat (3) begin
                @(negedge clk);
                check("R11 done", {31'h0, done}, 32'h0);
            end
            check("R12 result held", {16'h0, result}, {16'h0, held});
        end

        // constrained random
        for (int k = 0; k < 400; k++) begin
            logic [2:0] c;
            logic [1:0] o;
            c = 3'($urandom_range(0, 4));
            o = 2'($urandom_range(0, 2));
            run_op(c, o, 1'($urandom()), 16'($urandom()), 16'($urandom()), 5'($urandom()));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule